// File: doc/BRIEF.md
# Coin-Accumulating Release Controller

This block tracks the credit put into a single coin slot that takes five-cent and ten-cent coins. Each coin is signalled by a one-clock pulse on its own input. Credit builds up in steps of 0, 5, 10 and 15 cents. When the credit reaches 15 cents the release output goes high. Any further coins are absorbed with no change, and the credit stays at 15 cents until a synchronous reset returns it to zero.

Two elaboration parameters pick the build variant:

- `ONEHOT_ENC` stores the credit either in two binary flops (0=00, 5=01, 10=10, 15=11) or in four one-hot flops (0=0001, 5=0010, 10=0100, 15=1000).
- `RETIMED_OUT` takes the release either as a decode of the current state or from a flop loaded with the decode of the next state, gated by reset.

Both choices change only the timing and area inside the block. The port behaviour is the same for every variant.

Top module: `coin_release_ctrl`

## Requirements
- R1: A high `rst` at a rising edge sets the credit to 0 cents, and `release_o` is low in the following cycle. This holds in every variant, and also in retimed mode.
- R2: With both coin inputs low at an edge, the credit keeps its value.
- R3: A five-cent pulse alone moves the credit from 0 to 5, from 5 to 10 and from 10 to 15 cents.
- R4: A ten-cent pulse alone moves the credit from 0 to 10, from 5 to 15 and from 10 to 15 cents.
- R5: At 15 cents, any coin pulse leaves the credit at 15 cents. `release_o` stays high until a reset.
- R6: A cycle with both coin inputs high is treated as no coin, and the credit is held.
- R7: `release_o` is high exactly in the cycles where the credit is 15 cents. It rises in the cycle after the edge that samples the completing coin, in both output modes.
- R8: All four combinations of `ONEHOT_ENC` and `RETIMED_OUT` give the same `release_o` sequence for the same input sequence.
- R9: In one-hot mode, exactly one state flop is set after every edge. Any pattern with no bits set or several bits set is loaded as 0 cents at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the credit |
| nickel_i | input | 1 | One-cycle pulse for a detected five-cent coin |
| dime_i | input | 1 | One-cycle pulse for a detected ten-cent coin |
| release_o | output | 1 | High while the credit has reached 15 cents |

## Verification
The coin orders that can reach 15 cents are each applied on their own: three five-cent coins, five then ten, ten then five, and ten then ten. These tell apart every arc into the full state. Extra coins after the full state and idle gaps between coins check saturation and holding. Cycles with both inputs high, placed at several credit levels, expose any decoder that adds a coin on the invalid pattern. A long pseudo-random run with resets mixed in is applied to all four variants at once against one model, so any timing difference between the registered and decoded release paths shows up as a miscompare.

// File: rtl/coin_pkg.sv
package coin_pkg;

   typedef enum logic [1:0] {
      CR_0  = 2'd0,
      CR_5  = 2'd1,
      CR_10 = 2'd2,
      CR_15 = 2'd3
   } credit_e;

   localparam int unsigned BIN_W = 2;
   localparam int unsigned HOT_W = 4;

   function automatic logic [HOT_W-1:0] to_hot(credit_e c);
      logic [HOT_W-1:0] v;
      v = '0;
      v[c] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/coin_next.sv
module coin_next
   import coin_pkg::*;
(
   input  credit_e cur,
   input  logic    nickel,
   input  logic    dime,
   output credit_e nxt,
   output logic    nxt_full
);

   logic only_n;
   logic only_d;

   assign only_n = nickel & ~dime;
   assign only_d = dime & ~nickel;

   always_comb begin
      nxt = cur;
      unique case (cur)
         CR_0: begin
            if (only_n)      nxt = CR_5;
            else if (only_d) nxt = CR_10;
         end
         CR_5: begin
            if (only_n)      nxt = CR_10;
            else if (only_d) nxt = CR_15;
         end
         CR_10: begin
            if (only_n | only_d) nxt = CR_15;
         end
         default: nxt = CR_15;
      endcase
   end

   assign nxt_full = (nxt == CR_15);

endmodule

// File: rtl/coin_state_store.sv
module coin_state_store
   import coin_pkg::*;
#(
   parameter bit ONEHOT_ENC = 1'b0
) (
   input  logic    clk,
   input  logic    rst,
   input  logic    nickel,
   input  logic    dime,
   input  credit_e nxt,
   output credit_e cur,
   output logic    cur_full
);

   localparam int unsigned ST_W = ONEHOT_ENC ? HOT_W : BIN_W;

   logic [ST_W-1:0] q;

   generate
      if (ONEHOT_ENC) begin : g_hot
         logic legal;
         assign legal = $onehot(q);

         always_ff @(posedge clk) begin
            if (rst)        q <= to_hot(CR_0);
            else if (!legal) q <= to_hot(CR_0);
            else            q <= to_hot(nxt);
         end

         always_comb begin
            unique case (q)
               4'b0010: cur = CR_5;
               4'b0100: cur = CR_10;
               4'b1000: cur = CR_15;
               default: cur = CR_0;
            endcase
         end
         assign cur_full = q[CR_15];

         p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> $onehot(q))
            else $error("one-hot state lost its single hot bit");
      end else begin : g_bin
         always_ff @(posedge clk) begin
            if (rst) q <= CR_0;
            else     q <= nxt;
         end
         assign cur      = credit_e'(q);
         assign cur_full = q[1] & q[0];
      end
   endgenerate

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!nickel && !dime) |=> $stable(cur))
      else $error("credit moved without a coin");

   p_both_r6: assert property (@(posedge clk) disable iff (rst)
      (nickel && dime) |=> $stable(cur))
      else $error("credit moved on a dual-coin cycle");

   p_nickel_r3: assert property (@(posedge clk) disable iff (rst)
      (cur == CR_0 && nickel && !dime) |=> (cur == CR_5))
      else $error("five-cent step from zero wrong");

   p_dime_r4: assert property (@(posedge clk) disable iff (rst)
      (cur == CR_5 && dime && !nickel) |=> (cur == CR_15))
      else $error("ten-cent step from five wrong");

   p_sat_r5: assert property (@(posedge clk) disable iff (rst)
      (cur == CR_15) |=> (cur == CR_15))
      else $error("full credit left without reset");

endmodule

// File: rtl/coin_release_out.sv
module coin_release_out #(
   parameter bit RETIMED_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic cur_full,
   input  logic nxt_full,
   output logic release_o
);

   generate
      if (RETIMED_OUT) begin : g_reg
         logic rel_q;
         always_ff @(posedge clk) begin
            rel_q <= nxt_full & ~rst;
         end
         assign release_o = rel_q;
      end else begin : g_dec
         assign release_o = cur_full;
      end
   endgenerate

endmodule

// File: rtl/coin_release_ctrl.sv
module coin_release_ctrl
   import coin_pkg::*;
#(
   parameter bit ONEHOT_ENC  = 1'b0,
   parameter bit RETIMED_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic nickel_i,
   input  logic dime_i,
   output logic release_o
);

   credit_e cur;
   credit_e nxt;
   logic    cur_full;
   logic    nxt_full;
   logic    rst_seen;

   generate
      if ($bits(credit_e) != BIN_W) begin : g_bad_w
         $error("credit type width must match binary state width");
      end
   endgenerate

   coin_next u_next (
      .cur      (cur),
      .nickel   (nickel_i),
      .dime     (dime_i),
      .nxt      (nxt),
      .nxt_full (nxt_full)
   );

   coin_state_store #(.ONEHOT_ENC(ONEHOT_ENC)) u_store (
      .clk      (clk),
      .rst      (rst),
      .nickel   (nickel_i),
      .dime     (dime_i),
      .nxt      (nxt),
      .cur      (cur),
      .cur_full (cur_full)
   );

   coin_release_out #(.RETIMED_OUT(RETIMED_OUT)) u_out (
      .clk       (clk),
      .rst       (rst),
      .cur_full  (cur_full),
      .nxt_full  (nxt_full),
      .release_o (release_o)
   );

   always_ff @(posedge clk) begin
      if (rst) rst_seen <= 1'b1;
      else if (rst_seen !== 1'b1) rst_seen <= 1'b0;
   end

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!release_o && cur == CR_0))
      else $error("reset did not clear credit and release");

   p_release_r7: assert property (@(posedge clk) disable iff (rst || rst_seen !== 1'b1)
      1'b1 |-> (release_o == (cur == CR_15)))
      else $error("release disagrees with full credit");

endmodule

// File: tb/coin_release_ctrl_bench.sv
module coin_release_ctrl_bench;

   logic clk = 1'b0;
   logic rst = 1'b0;
   logic nk  = 1'b0;
   logic dm  = 1'b0;
   logic [3:0] rel;

   int vectors = 0;
   int misses  = 0;
   int credit  = 0;
   bit armed   = 0;
   bit done    = 0;
   string prev_tag = "R1";

   always #4 clk = ~clk;

   coin_release_ctrl #(.ONEHOT_ENC(1'b0), .RETIMED_OUT(1'b0)) u_coin_release_ctrl (
      .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .release_o(rel[0]));
   coin_release_ctrl #(.ONEHOT_ENC(1'b1), .RETIMED_OUT(1'b0)) u_var_hot (
      .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .release_o(rel[1]));
   coin_release_ctrl #(.ONEHOT_ENC(1'b0), .RETIMED_OUT(1'b1)) u_var_ret (
      .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .release_o(rel[2]));
   coin_release_ctrl #(.ONEHOT_ENC(1'b1), .RETIMED_OUT(1'b1)) u_var_hot_ret (
      .clk(clk), .rst(rst), .nickel_i(nk), .dime_i(dm), .release_o(rel[3]));

   task automatic step(input bit r, input bit n, input bit d, input string tag);
      @(negedge clk);
      if (armed) begin
         for (int v = 0; v < 4; v++) begin
            vectors++;
            if (rel[v] !== (credit == 15)) begin
               misses++;
               $display("FAIL %s (R8 variant %0d) credit=%0d: release=%b expected %b",
                        prev_tag, v, credit, rel[v], (credit == 15));
            end
         end
      end
      rst = r; nk = n; dm = d;
      @(posedge clk);
      if (r) begin
         credit = 0;
         armed  = 1;
      end else if (n ^ d) begin
         credit = credit + (n ? 5 : 10);
         if (credit > 15) credit = 15;
      end
      prev_tag = tag;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired: finished=0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr;
      step(1, 0, 0, "R1");
      step(0, 0, 0, "R2");
      step(0, 0, 0, "R2");
      // three nickels, then extra coins at full (R3, R5, R7)
      step(0, 1, 0, "R3");
      step(0, 0, 0, "R2");
      step(0, 1, 0, "R3");
      step(0, 1, 0, "R7");
      step(0, 1, 0, "R5");
      step(0, 0, 1, "R5");
      step(0, 1, 1, "R5");
      step(0, 0, 0, "R5");
      step(1, 0, 0, "R1");
      // dime then nickel (R4, R3)
      step(0, 0, 1, "R4");
      step(0, 1, 1, "R6");
      step(0, 1, 0, "R3");
      step(0, 0, 0, "R7");
      step(1, 1, 0, "R1");
      // nickel then dime
      step(0, 1, 0, "R3");
      step(0, 1, 1, "R6");
      step(0, 0, 1, "R4");
      step(0, 0, 0, "R7");
      step(1, 0, 1, "R1");
      // two dimes, dual-coin at zero
      step(0, 1, 1, "R6");
      step(0, 0, 1, "R4");
      step(0, 0, 1, "R4");
      step(0, 0, 0, "R9");
      step(1, 0, 0, "R1");
      // pseudo-random traffic across all variants
      lfsr = 8'hA5;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step((lfsr[7:3] == 5'd0), lfsr[0] & lfsr[1], lfsr[2] & lfsr[6], "R8");
      end
      step(0, 0, 0, "R8");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule